// File: doc/BRIEF.md
# Dual-Phase Audio Serial Transmitter

This block turns parallel audio words into a serial bit stream. The stream is framed by a frame sync that comes from an external clock generator. Each drive edge of the bit clock arrives as a one-cycle strobe on the system clock. On each strobe the block samples the frame sync and moves the data line by one bit, most significant bit first. Words come from an upstream buffer through a valid/pop pair. The buffer offers a word, and the block takes it on the strobe that starts that word's slot.

A frame starts on a rising edge of the frame sync. The first bit goes out on that same strobe or one strobe later, as the data-delay setting selects. In single-phase mode the frame carries a programmed number of words back to back. In dual-phase mode a second phase starts on the falling edge of the frame sync, with the same delay. This is the arrangement for two-channel audio where each half of the frame-sync period holds one channel. Word length is 16 or 32 bits and applies to both phases. A missing word is sent as zeros, and a sticky flag records it.

Top module: `audio_ser_tx`

## Requirements
- R1: After reset, sdata and sdata_en are 0, underrun is 0 and word_pop stays low.
- R2: `enable` is examined only on a strobe that sees a rising frame-sync edge. While the block is idle it pops nothing and sdata/sdata_en stay 0. Dropping `enable` lets the current frame finish, and the block goes idle at the next rising edge.
- R3: With cfg_delay=0 the first bit of a phase is driven on the strobe that detects the frame-sync edge. With cfg_delay=1 it is driven on the following strobe.
- R4: Bits go out most significant first, one per bclk_drive strobe. sdata and sdata_en change only in cycles where bclk_drive is high.
- R5: cfg_wide=1 sends 32-bit words taken from word_data[31:0]. cfg_wide=0 sends 16-bit words taken from word_data[15:0]. The same length applies to every phase.
- R6: With cfg_dual=0 a frame carries cfg_words+1 words back to back, and a falling frame-sync edge has no effect.
- R7: With cfg_dual=1 a second phase starts at the falling frame-sync edge, after the same data delay. It carries cfg_words+1 words.
- R8: After the last bit of a phase, sdata and sdata_en are 0 until the next frame-sync edge that starts a phase.
- R9: If word_valid is low when a slot starts, the slot is sent as zeros with sdata_en high, and underrun is set. underrun stays set until reset.
- R10: word_pop is high for exactly one clock per slot: on the strobe that starts the slot, and only when word_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_drive | input | 1 | One-cycle strobe marking a bit-clock drive edge |
| fsync | input | 1 | Frame sync level, sampled on strobes; rising edge starts a frame |
| enable | input | 1 | Run request, taken at a frame start |
| cfg_wide | input | 1 | 1: 32-bit words, 0: 16-bit words |
| cfg_dual | input | 1 | 1: dual-phase frames |
| cfg_delay | input | 1 | Data delay in bit clocks (0 or 1) |
| cfg_words | input | 7 | Words per phase minus one |
| word_data | input | 32 | Word offered by the upstream buffer |
| word_valid | input | 1 | word_data holds a word |
| word_pop | output | 1 | Word taken this cycle |
| sdata | output | 1 | Serial data |
| sdata_en | output | 1 | High while a word bit is driven |
| underrun | output | 1 | Sticky: a slot started without a word |

## Verification
The embedded assertions check the rules that hold on every clock. Outputs move only on drive strobes. An idle sequencer stays idle until a rising frame edge. A popped word is driven on the next cycle. The underrun flag never clears and is raised by any slot that starts empty. The directed scenarios compare the serial stream bit by bit against a bench model built from the configuration. Only those scenarios can show correct bit order, the data-delay offset, word length, second-phase placement, quiet gaps, the gating of enable at frame starts, and zero-filled underrun slots.

// File: rtl/audio_tx_pkg.sv
// Shared types for the serial audio transmitter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package audio_tx_pkg;
    // Action the shifter performs on a drive strobe
    typedef enum logic [1:0] {
        ACT_QUIET = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SHIFT = 2'd2
    } tx_act_e;

    // Slot sequencer state
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WAIT  = 2'd1,
        S_SHIFT = 2'd2,
        S_HOLD  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/audio_tx_fs_edge.sv
// Frame-sync edge detector.
// Samples fsync on each drive strobe and flags rising/falling edges
// relative to the previous strobe's sample. Outputs are meaningful only
// while strobe is high. Assumes fsync is stable around each strobe.
module audio_tx_fs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic fsync,
    output logic rise,
    output logic fall
);
    logic fs_q;

    // Remember the frame-sync level seen at the last drive strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      fs_q <= 1'b0;
        else if (strobe) fs_q <= fsync;
    end

    assign rise = fsync & ~fs_q;
    assign fall = ~fsync & fs_q;
endmodule

// File: rtl/audio_tx_slot_seq.sv
// Slot and phase sequencer.
// Decides per drive strobe whether the shifter loads a new word, shifts,
// or stays quiet. Starts phases on frame-sync edges (rising always,
// falling only in dual-phase mode), applies the data delay, and counts
// words in the phase. Assumes word_end is high when the shifter's current
// bit is the last of its word.
module audio_tx_slot_seq
    import audio_tx_pkg::*;
#(
    parameter int FLEN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              rise,
    input  logic              fall,
    input  logic              enable,
    input  logic              cfg_dual,
    input  logic              cfg_delay,
    input  logic [FLEN_W-1:0] cfg_words,
    input  logic              word_end,
    output tx_act_e           act
);
    tx_state_e         st, st_n;
    logic [FLEN_W-1:0] words_left, wl_n;
    logic              phase_start;

    assign phase_start = (rise & enable) | (fall & cfg_dual & (st != S_IDLE));

    // Next-state and action decode for the current strobe
    always_comb begin
        st_n = st;
        wl_n = words_left;
        act  = ACT_QUIET;
        if (phase_start) begin
            wl_n = cfg_words;
            if (cfg_delay) begin
                st_n = S_WAIT;
            end else begin
                st_n = S_SHIFT;
                act  = ACT_LOAD;
            end
        end else if (rise) begin
            st_n = S_IDLE;
        end else begin
            unique case (st)
                S_WAIT: begin
                    act  = ACT_LOAD;
                    st_n = S_SHIFT;
                end
                S_SHIFT: begin
                    if (!word_end) begin
                        act = ACT_SHIFT;
                    end else if (words_left != '0) begin
                        act  = ACT_LOAD;
                        wl_n = words_left - 1'b1;
                    end else begin
                        st_n = S_HOLD;
                    end
                end
                default: ;
            endcase
        end
    end

    // Advance the sequencer on drive strobes only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_IDLE;
            words_left <= '0;
        end else if (strobe) begin
            st         <= st_n;
            words_left <= wl_n;
        end
    end

    // R2: an idle transmitter stays idle until a rising frame edge
    a_r2_idle_until_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && st == S_IDLE && !rise) |=> st == S_IDLE);
endmodule

// File: rtl/audio_tx_shifter.sv
// Output shift register.
// Carries out the sequencer's action on each drive strobe: load a word
// (16-bit words are left-aligned), shift out the next bit MSB first, or
// drive quiet zeros. A missing word loads as zeros. Assumes act is valid
// whenever strobe is high.
module audio_tx_shifter
    import audio_tx_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int HALF_W = WORD_W / 2,
    localparam int CNT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  tx_act_e           act,
    input  logic              cfg_wide,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_valid,
    output logic              sdata,
    output logic              sdata_en,
    output logic              word_end
);
    logic [WORD_W-1:0] shreg, src;
    logic [CNT_W-1:0]  bits_left;

    // Select and align the incoming word, zeros if none is available
    always_comb begin
        if (!word_valid)   src = '0;
        else if (cfg_wide) src = word_data;
        else               src = {word_data[HALF_W-1:0], {HALF_W{1'b0}}};
    end

    // Drive one bit per strobe according to the requested action
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
            sdata     <= 1'b0;
            sdata_en  <= 1'b0;
        end else if (strobe) begin
            unique case (act)
                ACT_LOAD: begin
                    sdata     <= src[WORD_W-1];
                    shreg     <= src << 1;
                    bits_left <= cfg_wide ? CNT_W'(WORD_W - 1) : CNT_W'(HALF_W - 1);
                    sdata_en  <= 1'b1;
                end
                ACT_SHIFT: begin
                    sdata     <= shreg[WORD_W-1];
                    shreg     <= shreg << 1;
                    bits_left <= bits_left - 1'b1;
                    sdata_en  <= 1'b1;
                end
                default: begin
                    sdata     <= 1'b0;
                    bits_left <= '0;
                    sdata_en  <= 1'b0;
                end
            endcase
        end
    end

    assign word_end = (bits_left == '0);

    // R4: the line moves only on drive strobes
    a_r4_stable_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(sdata) && $stable(sdata_en)));
endmodule

// File: rtl/audio_ser_tx.sv
// Dual-phase audio serial transmitter, top level.
// Ties the frame-sync edge detector, slot sequencer and shifter together,
// generates the buffer pop, and keeps the sticky underrun flag.
// Assumes bclk_drive is a single-cycle strobe per bit-clock drive edge.
module audio_ser_tx
    import audio_tx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int FLEN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_drive,
    input  logic              fsync,
    input  logic              enable,
    input  logic              cfg_wide,
    input  logic              cfg_dual,
    input  logic              cfg_delay,
    input  logic [FLEN_W-1:0] cfg_words,
    input  logic [WORD_W-1:0] word_data,
    input  logic              word_valid,
    output logic              word_pop,
    output logic              sdata,
    output logic              sdata_en,
    output logic              underrun
);
    logic    fs_rise, fs_fall, word_end, slot_start;
    tx_act_e act;

    audio_tx_fs_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (bclk_drive),
        .fsync  (fsync),
        .rise   (fs_rise),
        .fall   (fs_fall)
    );

    audio_tx_slot_seq #(.FLEN_W(FLEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (bclk_drive),
        .rise      (fs_rise),
        .fall      (fs_fall),
        .enable    (enable),
        .cfg_dual  (cfg_dual),
        .cfg_delay (cfg_delay),
        .cfg_words (cfg_words),
        .word_end  (word_end),
        .act       (act)
    );

    audio_tx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (bclk_drive),
        .act        (act),
        .cfg_wide   (cfg_wide),
        .word_data  (word_data),
        .word_valid (word_valid),
        .sdata      (sdata),
        .sdata_en   (sdata_en),
        .word_end   (word_end)
    );

    assign slot_start = bclk_drive && (act == ACT_LOAD);
    assign word_pop   = slot_start && word_valid;

    // Record any slot that started without a word
    always_ff @(posedge clk) begin
        if (!rst_n)                        underrun <= 1'b0;
        else if (slot_start && !word_valid) underrun <= 1'b1;
    end

    // R9: underrun never clears once set
    a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
    // R9: an empty slot start raises the flag
    a_r9_empty_slot_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && !word_valid) |=> underrun);
    // R10: a popped word is driven on the line next cycle
    a_r10_pop_drives: assert property (@(posedge clk) disable iff (!rst_n)
        word_pop |=> sdata_en);
endmodule

// File: tb/tb_audio_ser_tx.sv
// Directed bench for the serial audio transmitter.
module tb_audio_ser_tx;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_drive = 1'b0;
    logic        fsync = 1'b0;
    logic        enable = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        cfg_dual = 1'b0;
    logic        cfg_delay = 1'b0;
    logic [6:0]  cfg_words = '0;
    logic [31:0] word_data;
    logic        word_valid;
    logic        word_pop, sdata, sdata_en, underrun;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] src [16];
    logic [7:0]  pop_cnt = '0;
    int          avail = 16;
    int          exp_idx = 0;
    logic        exp_under = 1'b0;
    logic [31:0] cur = '0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_ser_tx dut (
        .clk(clk), .rst_n(rst_n), .bclk_drive(bclk_drive), .fsync(fsync),
        .enable(enable), .cfg_wide(cfg_wide), .cfg_dual(cfg_dual),
        .cfg_delay(cfg_delay), .cfg_words(cfg_words), .word_data(word_data),
        .word_valid(word_valid), .word_pop(word_pop), .sdata(sdata),
        .sdata_en(sdata_en), .underrun(underrun)
    );

    // Upstream buffer model: offers src words in order, counts pops
    assign word_valid = (int'(pop_cnt) < avail);
    assign word_data  = src[pop_cnt[3:0]];
    always @(posedge clk) if (word_pop) pop_cnt <= pop_cnt + 8'd1;

    task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
        end
    endtask

    // One drive strobe with the given frame-sync level; sample after the edge
    task automatic strobe_once(input logic fs);
        @(negedge clk);
        fsync = fs;
        bclk_drive = 1'b1;
        @(negedge clk);
        bclk_drive = 1'b0;
    endtask

    // Run one frame and compare every driven bit with the bench model
    task automatic run_frame(input int period, input int fs_high, input int len,
                             input int nwords, input bit active, input int off_at,
                             input string req);
        for (int s = 0; s < period; s++) begin
            int  base, b;
            logic eb, een;
            if (s == off_at) enable = 1'b0;
            strobe_once(s < fs_high);
            base = (cfg_dual && s >= fs_high) ? fs_high : 0;
            b    = s - base - int'(cfg_delay);
            eb = 1'b0; een = 1'b0;
            if (active && b >= 0 && b < nwords * len) begin
                if (b % len == 0) begin
                    if (exp_idx < avail) begin
                        cur = src[exp_idx];
                        exp_idx++;
                    end else begin
                        cur = '0;
                        exp_under = 1'b1;
                    end
                end
                eb  = cur[len - 1 - (b % len)];
                een = 1'b1;
            end
            check(sdata_en == een, {req, " R8 enable"}, int'(sdata_en), int'(een));
            check(sdata == eb, {req, " R4 data"}, int'(sdata), int'(eb));
            repeat (2) @(negedge clk);
            check(sdata == eb && sdata_en == een, "R4 hold between strobes",
                  int'({sdata_en, sdata}), int'({een, eb}));
        end
        check(int'(pop_cnt) == exp_idx, "R10 pop count", int'(pop_cnt), exp_idx);
        check(underrun == exp_under, "R9 flag", int'(underrun), int'(exp_under));
    endtask

    task automatic t_reset();
        check(sdata == 1'b0 && sdata_en == 1'b0, "R1 outputs", int'({sdata_en, sdata}), 0);
        check(underrun == 1'b0, "R1 underrun", int'(underrun), 0);
        check(pop_cnt == 8'd0, "R1 no pop", int'(pop_cnt), 0);
    endtask

    task automatic t_enable_gate();
        strobe_once(1'b1);          // rising edge while disabled
        enable = 1'b1;              // requested mid-frame
        strobe_once(1'b1);
        strobe_once(1'b0);
        check(sdata_en == 1'b0 && sdata == 1'b0, "R2 idle mid-frame", int'({sdata_en, sdata}), 0);
        strobe_once(1'b0);
        check(pop_cnt == 8'd0, "R2 no pop before frame", int'(pop_cnt), 0);
    endtask

    task automatic t_single_d1_16();
        cfg_dual = 0; cfg_delay = 1; cfg_wide = 0; cfg_words = 7'd2;
        run_frame(52, 1, 16, 3, 1'b1, -1, "R3 R5 R6 single delay1 16b");
    endtask

    task automatic t_single_d0_32();
        cfg_dual = 0; cfg_delay = 0; cfg_wide = 1; cfg_words = 7'd1;
        run_frame(70, 2, 32, 2, 1'b1, -1, "R3 R5 R6 single delay0 32b");
    endtask

    task automatic t_dual_d1_16();
        cfg_dual = 1; cfg_delay = 1; cfg_wide = 0; cfg_words = 7'd0;
        run_frame(40, 20, 16, 1, 1'b1, -1, "R7 dual delay1 16b");
    endtask

    task automatic t_dual_d0_32();
        cfg_dual = 1; cfg_delay = 0; cfg_wide = 1; cfg_words = 7'd0;
        run_frame(66, 33, 32, 1, 1'b1, -1, "R7 R5 dual delay0 32b");
    endtask

    task automatic t_underrun();
        cfg_dual = 0; cfg_delay = 1; cfg_wide = 0; cfg_words = 7'd1;
        avail = exp_idx + 1;
        run_frame(36, 1, 16, 2, 1'b1, -1, "R9 empty slot");
        avail = 16;
        run_frame(36, 1, 16, 2, 1'b1, -1, "R9 after refill");
        check(underrun == 1'b1, "R9 sticky", int'(underrun), 1);
    endtask

    task automatic t_disable();
        cfg_dual = 0; cfg_delay = 0; cfg_wide = 0; cfg_words = 7'd0;
        run_frame(20, 1, 16, 1, 1'b1, 3, "R2 finish frame after disable");
        run_frame(20, 1, 16, 1, 1'b0, -1, "R2 idle after disable");
    endtask

    initial begin
        for (int i = 0; i < 16; i++)
            src[i] = 32'hC35A_96E1 ^ (32'(i) * 32'h2F1B_7A4D);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_gate();
        t_single_d1_16();
        t_single_d0_32();
        t_dual_d1_16();
        t_dual_d0_32();
        t_underrun();
        t_disable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule